// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block joins two identical eight-input interrupt controllers into one sixteen-line source of interrupts for a processor. The upper controller, the primary, sends a single request line to the CPU. The lower controller, the secondary, sends its own request into primary input 2. Each controller keeps three registers: a mask, a request latch and an in-service set. Software reaches them through a small byte-wide port map. Each controller has a command address and a data address. The address field `bus_addr[1]` selects the controller (0 = primary, 1 = secondary). `bus_addr[0]` selects the port (0 = command, 1 = data).

Each controller starts in state ST_RUN. A command byte with bit 4 set (0x11 in use) takes the transition ICW1→ST_GET_BASE and clears the controller. The next three data-port writes walk ST_GET_BASE→ST_GET_CASC→ST_GET_MODE→ST_RUN:
- The first loads the vector base. Only the upper five bits are kept.
- The second loads the cascade byte. On the primary this is a mask of the inputs that carry a secondary. On the secondary, bits 2:0 hold its identity.
- The third, the mode byte, is accepted and then ignored.

A new bit-4 command in any state restarts the sequence. In ST_RUN:
- A data write loads the mask.
- A command byte 011_00_nnn is a specific end-of-interrupt for level nnn.
- A command byte 0_xx_01_x1r selects the read-back register: r=1 reads in-service, r=0 reads request.

A one-cycle `inta` pulse acknowledges the highest-priority forwarded request. In the next cycle the 8-bit vector appears on `vec_out` with `vec_valid` high. When the primary's winning input is a cascade input, the secondary whose identity matches that level supplies the vector instead.

Top module: `cascaded_pic`

## Requirements
- R1: After reset, `cpu_int` and `vec_valid` are 0. Both masks read 0xFF on the data ports. Both request registers read 0 on the command ports.
- R2: A command write with bit 4 set does two things. It holds that controller's request output low until three data writes have completed the sequence. It clears the mask, request and in-service registers, and clears the read select to request. It also re-arms edge detection, so a line held high through initialization raises no request until it goes low and high again.
- R3: The vector is the base loaded by the first initialization data write, with bits 2:0 replaced by the level. With bases 0x20 and 0x28, primary level n gives 0x20+n and secondary level n gives 0x28+n.
- R4: In ST_RUN a data-port write loads the mask and reads back on the same port. A 1 in bit n stops level n from being forwarded but does not stop it being latched.
- R5: A rising edge on a line latches its request bit. The bit clears when the line goes low. A line held high raises only one interrupt.
- R6: Priority is fixed, with level 0 highest. A latched, unmasked request is forwarded only if its level is lower-numbered than every in-service level.
- R7: When `inta` is high for one cycle, the next cycle has `vec_valid`=1 and the vector. The winning level moves from request to in-service, and at most one in-service bit is set per acknowledge.
- R8: Primary input 2 is driven by the secondary's request output. `irq_in[2]` has no effect. A primary win on a level marked in its cascade byte takes the vector from the secondary whose identity equals that level (identity 2).
- R9: A command write of 0x60+n clears in-service bit n of the addressed controller only.
- R10: Command byte 0x0B makes command-port reads return in-service, and 0x0A makes them return request.
- R11: If an acknowledge arrives with no forwarded request, the vector is base+7 and no in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Bit 1 selects the controller, bit 0 selects data (1) or command (0) |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read-back byte for the addressed port |
| irq_in | input | 16 | Lines 7:0 go to the primary, lines 15:8 to the secondary; bit 2 is unused |
| inta | input | 1 | One-cycle acknowledge |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, the cycle after `inta` |
| vec_out | output | 8 | Acknowledged vector |

## Verification
Some properties are checked by assertions on every cycle:
- in-service bits are set only by an acknowledge, and never more than one at a time;
- initialization empties the mask, request and in-service registers;
- a specific end-of-interrupt clears its bit;
- `vec_valid` follows `inta` by exactly one cycle.

Other behaviour can only be shown by the bench's scenarios: priority between simultaneous lines, blocking by nested in-service levels, vectors routed from the secondary, spurious level 7 after a line vanishes, edge re-arming across initialization, and the read-select choice.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
    localparam int LINES     = 8;
    localparam int LVL_W     = $clog2(LINES);
    localparam int BYTE_W    = 8;
    localparam int CASC_LINE = 2;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_GET_BASE,
        ST_GET_CASC,
        ST_GET_MODE
    } init_state_e;

    function automatic logic cmd_is_init(input logic [BYTE_W-1:0] b);
        return b[4];
    endfunction

    function automatic logic cmd_is_eoi(input logic [BYTE_W-1:0] b);
        return (b[7:5] == 3'b011) && (b[4:3] == 2'b00);
    endfunction

    function automatic logic cmd_is_rdsel(input logic [BYTE_W-1:0] b);
        return (b[7] == 1'b0) && (b[4:3] == 2'b01);
    endfunction
endpackage

// File: rtl/cpic_prio.sv
module cpic_prio #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] bits_in,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits_in[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/cpic_unit.sv
module cpic_unit
    import cpic_pkg::*;
#(
    parameter int N = LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req,
    input  logic              wr_cmd,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ack_in,
    output logic [BYTE_W-1:0] cmd_rd,
    output logic [BYTE_W-1:0] data_rd,
    output logic [N-1:0]      cfg_out,
    output logic              int_req,
    output logic [BYTE_W-1:0] vec
);
    localparam int W = $clog2(N);

    init_state_e       st_q, st_d;
    logic [N-1:0]      imr_q, irr_q, isr_q, req_q;
    logic [BYTE_W-1:0] base_q;
    logic [N-1:0]      casc_q;
    logic              rd_isr_q;

    logic init_wr, eoi_wr, rdsel_wr, running;
    logic load_base, load_casc, load_mask;
    logic pend_any, srv_any, ack_take;
    logic [W-1:0] pend_idx, srv_idx;
    logic [N-1:0] pend, rise, set_mask, eoi_mask;

    // ---- state register ----
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // ---- next state ----
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:      st_d = ST_RUN;
            ST_GET_BASE: if (wr_data) st_d = ST_GET_CASC;
            ST_GET_CASC: if (wr_data) st_d = ST_GET_MODE;
            ST_GET_MODE: if (wr_data) st_d = ST_RUN;
        endcase
        if (init_wr) st_d = ST_GET_BASE;
    end

    // ---- per-state outputs ----
    always_comb begin
        init_wr   = wr_cmd && cmd_is_init(wdata);
        eoi_wr    = wr_cmd && cmd_is_eoi(wdata);
        rdsel_wr  = wr_cmd && cmd_is_rdsel(wdata) && wdata[1];
        running   = (st_q == ST_RUN);
        load_base = (st_q == ST_GET_BASE) && wr_data;
        load_casc = (st_q == ST_GET_CASC) && wr_data;
        load_mask = running && wr_data;
    end

    assign pend = irr_q & ~imr_q;

    cpic_prio #(.N(N), .W(W)) u_pend (.bits_in(pend),  .found(pend_any), .idx(pend_idx));
    cpic_prio #(.N(N), .W(W)) u_srv  (.bits_in(isr_q), .found(srv_any),  .idx(srv_idx));

    assign int_req  = running && pend_any && (!srv_any || (pend_idx < srv_idx));
    assign ack_take = ack_in && int_req;
    assign rise     = req & ~req_q;
    assign set_mask = ack_take ? (N'(1) << pend_idx) : '0;
    assign eoi_mask = eoi_wr ? (N'(1) << wdata[W-1:0]) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q    <= '1;
            irr_q    <= '0;
            isr_q    <= '0;
            req_q    <= '0;
            base_q   <= '0;
            casc_q   <= '0;
            rd_isr_q <= 1'b0;
        end else if (init_wr) begin
            imr_q    <= '0;
            irr_q    <= '0;
            isr_q    <= '0;
            req_q    <= req;
            rd_isr_q <= 1'b0;
        end else begin
            req_q <= req;
            irr_q <= (irr_q | rise) & req & ~set_mask;
            isr_q <= (isr_q & ~eoi_mask) | set_mask;
            if (load_base) base_q <= {wdata[BYTE_W-1:W], {W{1'b0}}};
            if (load_casc) casc_q <= wdata[N-1:0];
            if (load_mask) imr_q  <= wdata[N-1:0];
            if (rdsel_wr)  rd_isr_q <= wdata[0];
        end
    end

    assign cmd_rd  = rd_isr_q ? isr_q : irr_q;
    assign data_rd = imr_q;
    assign cfg_out = casc_q;
    assign vec     = {base_q[BYTE_W-1:W], int_req ? pend_idx : W'(N - 1)};

    // R7
    isr_set_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_in |=> ((isr_q & ~$past(isr_q)) == '0));

    // R7
    isr_single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(isr_q & ~$past(isr_q)) <= 1));

    // R2
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[4]) |=> (imr_q == '0 && isr_q == '0 && irr_q == '0));

    // R9
    eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[7:5] == 3'b011 && wdata[4:3] == 2'b00 && !ack_in)
        |=> !isr_q[$past(wdata[W-1:0])]);
endmodule

// File: rtl/cascaded_pic.sv
module cascaded_pic
    import cpic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [2*LINES-1:0]  irq_in,
    input  logic                inta,
    output logic                cpu_int,
    output logic                vec_valid,
    output logic [BYTE_W-1:0]   vec_out
);
    logic [LINES-1:0]  m_req, s_req, m_cfg, s_cfg;
    logic [BYTE_W-1:0] m_cmd, m_dat, s_cmd, s_dat, m_vec, s_vec;
    logic              m_int, s_int;
    logic [LVL_W-1:0]  m_win;
    logic              m_hit, s_sel, use_sec, s_ack;
    logic [BYTE_W-1:0] vec_q;
    logic              valid_q;

    for (genvar i = 0; i < LINES; i++) begin : g_mreq
        if (i == CASC_LINE) begin : g_casc
            assign m_req[i] = s_int;
        end else begin : g_pin
            assign m_req[i] = irq_in[i];
        end
    end
    assign s_req = irq_in[2*LINES-1:LINES];

    cpic_unit #(.N(LINES)) u_pri (
        .clk(clk), .rst_n(rst_n), .req(m_req),
        .wr_cmd(bus_wr && bus_addr == 2'b00),
        .wr_data(bus_wr && bus_addr == 2'b01),
        .wdata(bus_wdata), .ack_in(inta),
        .cmd_rd(m_cmd), .data_rd(m_dat), .cfg_out(m_cfg),
        .int_req(m_int), .vec(m_vec)
    );

    assign m_win   = m_vec[LVL_W-1:0];
    assign m_hit   = m_int && m_cfg[m_win];
    assign s_sel   = (s_cfg[LVL_W-1:0] == m_win) && (s_cfg[LINES-1:LVL_W] == '0);
    assign use_sec = m_hit && s_sel;
    assign s_ack   = inta && use_sec;

    cpic_unit #(.N(LINES)) u_sec (
        .clk(clk), .rst_n(rst_n), .req(s_req),
        .wr_cmd(bus_wr && bus_addr == 2'b10),
        .wr_data(bus_wr && bus_addr == 2'b11),
        .wdata(bus_wdata), .ack_in(s_ack),
        .cmd_rd(s_cmd), .data_rd(s_dat), .cfg_out(s_cfg),
        .int_req(s_int), .vec(s_vec)
    );

    always_comb begin
        unique case (bus_addr)
            2'b00: bus_rdata = m_cmd;
            2'b01: bus_rdata = m_dat;
            2'b10: bus_rdata = s_cmd;
            2'b11: bus_rdata = s_dat;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= inta;
            if (inta) vec_q <= use_sec ? s_vec : m_vec;
        end
    end

    assign cpu_int   = m_int;
    assign vec_valid = valid_q;
    assign vec_out   = vec_q;

    // R7
    vec_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> vec_valid);

    // R7
    vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |=> !vec_valid);
endmodule

// File: tb/cascaded_pic_bench.sv
module cascaded_pic_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] irq_in = '0;
    logic        inta = 1'b0;
    logic        cpu_int, vec_valid;
    logic [7:0]  vec_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cascaded_pic u_cascaded_pic (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .inta(inta), .cpu_int(cpu_int), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // {expect_int, irq, primary mask, secondary mask, vector}
    localparam logic [40:0] VECS [10] = '{
        {1'b1, 16'h0001, 8'h00, 8'h00, 8'h20},  // R3 level 0
        {1'b1, 16'h0008, 8'h00, 8'h00, 8'h23},  // R3 level 3
        {1'b1, 16'h0009, 8'h00, 8'h00, 8'h20},  // R6 0 beats 3
        {1'b1, 16'h0100, 8'h00, 8'h00, 8'h28},  // R8 secondary 0
        {1'b1, 16'h8000, 8'h00, 8'h00, 8'h2F},  // R8 secondary 7
        {1'b1, 16'h0102, 8'h00, 8'h00, 8'h21},  // R6 primary 1 beats cascade
        {1'b1, 16'h0012, 8'h02, 8'h00, 8'h24},  // R4 mask skips level 1
        {1'b1, 16'h0300, 8'h00, 8'h01, 8'h29},  // R4 secondary mask
        {1'b0, 16'h0010, 8'h10, 8'h00, 8'h00},  // R4 fully masked
        {1'b1, 16'h8100, 8'h00, 8'h00, 8'h28}   // R6 secondary priority
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack(output logic v, output logic [7:0] vv);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        v = vec_valid; vv = vec_out;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic init_pri;
        wr(2'b00, 8'h11); wr(2'b01, 8'h20); wr(2'b01, 8'h04); wr(2'b01, 8'h01);
    endtask

    task automatic init_sec;
        wr(2'b10, 8'h11); wr(2'b11, 8'h28); wr(2'b11, 8'h02); wr(2'b11, 8'h01);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic v;
        logic [7:0] vv;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 cpu_int", cpu_int, 0);
        chk("R1 vec_valid", vec_valid, 0);
        rd(2'b01, d); chk("R1 primary mask", d, 8'hFF);
        rd(2'b11, d); chk("R1 secondary mask", d, 8'hFF);
        rd(2'b00, d); chk("R1 primary request", d, 8'h00);

        init_pri();
        init_sec();
        rd(2'b01, d); chk("R2 mask cleared", d, 8'h00);

        // table walk
        for (int k = 0; k < 10; k++) begin
            wr(2'b01, VECS[k][23:16]);
            wr(2'b11, VECS[k][15:8]);
            irq_in = VECS[k][39:24];
            idle(4);
            chk($sformatf("R6 entry %0d cpu_int", k), cpu_int, VECS[k][40]);
            if (VECS[k][40]) begin
                ack(v, vv);
                chk($sformatf("R7 entry %0d valid", k), v, 1);
                chk($sformatf("R3 entry %0d vector", k), vv, VECS[k][7:0]);
                if (VECS[k][7:0] >= 8'h28) begin
                    wr(2'b10, 8'h60 | (VECS[k][7:0] & 8'h07));
                    wr(2'b00, 8'h62);
                end else begin
                    wr(2'b00, 8'h60 | (VECS[k][7:0] & 8'h07));
                end
            end
            irq_in = '0;
            idle(3);
        end
        wr(2'b01, 8'h00);
        wr(2'b11, 8'h00);

        // R4 mask readback
        wr(2'b01, 8'h5A);
        rd(2'b01, d); chk("R4 mask readback", d, 8'h5A);
        wr(2'b01, 8'h00);

        // R4 / R10 masked line still latched, read request
        wr(2'b01, 8'h40);
        irq_in[6] = 1'b1;
        idle(3);
        chk("R4 masked no int", cpu_int, 0);
        wr(2'b00, 8'h0A);
        rd(2'b00, d); chk("R10 request readback", d, 8'h40);
        irq_in = '0;
        idle(2);
        wr(2'b01, 8'h00);

        // R8 irq_in[2] ignored
        irq_in[2] = 1'b1;
        idle(3);
        chk("R8 pin 2 no int", cpu_int, 0);
        rd(2'b00, d); chk("R8 pin 2 not latched", d, 8'h00);
        irq_in = '0;
        idle(2);

        // R11 spurious + R5 request clears when line drops
        irq_in[5] = 1'b1;
        idle(3);
        chk("R5 int raised", cpu_int, 1);
        irq_in[5] = 1'b0;
        ack(v, vv);
        chk("R11 spurious vector", vv, 8'h27);
        wr(2'b00, 8'h0B);
        rd(2'b00, d); chk("R11 no in-service", d, 8'h00);
        wr(2'b00, 8'h0A);
        rd(2'b00, d); chk("R5 request cleared", d, 8'h00);

        // R6 nesting, R5 held lines
        irq_in[5] = 1'b1;
        idle(3);
        ack(v, vv); chk("R6 first vector", vv, 8'h25);
        irq_in[6] = 1'b1;
        idle(3);
        chk("R6 lower blocked", cpu_int, 0);
        irq_in[3] = 1'b1;
        idle(3);
        chk("R6 higher nests", cpu_int, 1);
        ack(v, vv); chk("R6 nested vector", vv, 8'h23);
        wr(2'b00, 8'h0B);
        rd(2'b00, d); chk("R10 in-service readback", d, 8'h28);
        wr(2'b00, 8'h63);
        idle(1);
        chk("R6 still blocked by 5", cpu_int, 0);
        wr(2'b00, 8'h65);
        idle(1);
        chk("R6 level 6 now forwarded", cpu_int, 1);
        ack(v, vv); chk("R6 level 6 vector", vv, 8'h26);
        wr(2'b00, 8'h66);
        idle(2);
        chk("R5 held lines no repeat", cpu_int, 0);
        wr(2'b00, 8'h0A);
        irq_in = '0;
        idle(2);

        // R9 EOI scoped to one controller
        irq_in[9] = 1'b1;
        idle(4);
        ack(v, vv); chk("R8 secondary vector", vv, 8'h29);
        wr(2'b00, 8'h0B);
        wr(2'b10, 8'h0B);
        rd(2'b00, d); chk("R8 primary in-service 2", d, 8'h04);
        rd(2'b10, d); chk("R7 secondary in-service", d, 8'h02);
        wr(2'b10, 8'h61);
        rd(2'b10, d); chk("R9 secondary cleared", d, 8'h00);
        rd(2'b00, d); chk("R9 primary untouched", d, 8'h04);
        wr(2'b00, 8'h62);
        rd(2'b00, d); chk("R9 primary cleared", d, 8'h00);
        wr(2'b00, 8'h0A);
        wr(2'b10, 8'h0A);
        irq_in = '0;
        idle(3);

        // R2 init suppresses, re-arms edges
        irq_in[1] = 1'b1;
        idle(3);
        chk("R2 pre-init int", cpu_int, 1);
        wr(2'b00, 8'h11);
        chk("R2 int dropped in init", cpu_int, 0);
        wr(2'b01, 8'h20); wr(2'b01, 8'h04); wr(2'b01, 8'h01);
        idle(3);
        chk("R2 held line not re-armed", cpu_int, 0);
        rd(2'b01, d); chk("R2 mask after re-init", d, 8'h00);
        irq_in = '0;
        idle(2);
        irq_in[1] = 1'b1;
        idle(3);
        chk("R2 fresh edge accepted", cpu_int, 1);
        ack(v, vv); chk("R3 vector after re-init", vv, 8'h21);
        irq_in = '0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule